// File: doc/BRIEF.md
# Drift-Corrected Delta Tick Generator

This block produces the delta strobe that paces a gate schedule engine. The engine and a rate-adjustable PTP clock share one oscillator. One scheduler tick is the oscillator period, and a nominal delta is 25 of those ticks. The PTP clock is fed to the block as a per-tick increment, in units of scheduler ticks with 16 fraction bits, so a rate-corrected PTP clock shows up as an increment slightly above or below 1.0.

A correction period is programmed in PTP time, as a whole number of ticks. While the block is enabled, it adds up the PTP increments. When the PTP time elapsed in the current period reaches the programmed length, a period boundary occurs. At that boundary the block compares the period length with the number of scheduler ticks that actually passed. The difference is the drift. It is added to a signed pending correction. Each delta that starts after the boundary takes at most 5 ticks of that correction, shortening the delta when PTP runs fast and lengthening it when PTP runs slow, and the rest carries to the following deltas. A shortened delta is therefore never below 20 ticks, which keeps the slew within 5 ticks per 20. Stepping the PTP clock is outside the scope of the block.

Top module: `dtg_delta_gen`

## Requirements
- R1: While rst_ni is low, strobe_o stays low. After release the first strobe comes on the 24th rising edge, and every delta is 25 ticks until a correction is pending.
- R2: strobe_o is a single-cycle pulse on the last tick of each delta. It is never high in two consecutive cycles.
- R3: While en_i is low, every delta that starts is exactly 25 ticks, whatever ptp_inc_i and period_i hold.
- R4: With en_i high and ptp_inc_i at exactly 1.0 (0x10000), measured drift is zero and all deltas stay 25 ticks.
- R5: A boundary occurs on the first enabled tick where the summed increments reach period_i. The drift is period_i minus the ticks counted in that period. A positive drift shortens the following deltas.
- R6: A negative drift, meaning PTP runs slow, lengthens the following deltas.
- R7: Each delta differs from 25 by at most 5 ticks, so every delta is between 20 and 30 ticks long.
- R8: Correction beyond 5 ticks carries into the following deltas until the pending count is used up. A drift of 7 gives one delta of 20 followed by one of 23.
- R9: A correction affects only the deltas that start after the boundary. The delta in flight keeps the length it was given.
- R10: Driving en_i low clears the pending correction and the period measurement. When the block is enabled again, no earlier correction appears.
- R11: When period_i is 0, no boundary occurs and the pending correction changes only as deltas absorb it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scheduler tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables drift measurement and correction |
| ptp_inc_i | input | 18 | PTP time advance per tick, in ticks with 16 fraction bits |
| period_i | input | 20 | Correction period in PTP ticks; 0 means no boundaries |
| strobe_o | output | 1 | Pulses on the last tick of each delta |

## Verification
A fault in the phase accumulator or the tick count shows up as a wrong drift. That error is visible at the ports on the first delta that starts after the boundary, as a strobe spacing other than the one the increment predicts. A fault in the pending correction shows up either as a delta outside 20 to 30 ticks, as shortening that continues past the expected number of deltas, or as leftover correction after a disable and re-enable. Each of these is visible within one or two deltas of the faulty state. The directed scenarios set the drift to exact values of +20, +7 and -25, so the order in which the corrected lengths appear is fully predictable.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int unsigned NOM_TICKS  = 25;
  localparam int unsigned SLEW_TICKS = 5;
  localparam int unsigned FRAC_W     = 16;
  localparam int unsigned PER_W      = 20;

  function automatic longint sclamp(longint v, longint lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction
endpackage

// File: rtl/dtg_period_meter.sv
module dtg_period_meter #(
  parameter int unsigned PER_W  = 20,
  parameter int unsigned FRAC_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic [FRAC_W+1:0]        ptp_inc_i,
  input  logic [PER_W-1:0]         period_i,
  output logic                     bnd_o,
  output logic signed [PER_W+2:0]  drift_o
);
  localparam int unsigned PH_W  = PER_W + FRAC_W + 2;
  localparam int unsigned CNT_W = PER_W + 2;

  logic [PH_W-1:0]  phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] ph_int;

  always_comb begin
    phase_n = phase_q + PH_W'(ptp_inc_i);
    ph_int  = phase_n[PH_W-1:FRAC_W];
    cnt_n   = (cnt_q == '1) ? cnt_q : cnt_q + CNT_W'(1);
    bnd_o   = en_i && (period_i != '0) && (ph_int >= {2'b00, period_i});
    // positive: PTP ran ahead of the scheduler
    drift_o = $signed({3'b000, period_i}) - $signed({1'b0, cnt_n});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      cnt_q   <= '0;
    end else if (!en_i) begin
      phase_q <= '0;
      cnt_q   <= '0;
    end else if (bnd_o) begin
      phase_q <= phase_n - {2'b00, period_i, {FRAC_W{1'b0}}};
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/dtg_corr_bank.sv
module dtg_corr_bank #(
  parameter int unsigned DRIFT_W = 23,
  parameter int unsigned PEND_W  = 25,
  parameter int unsigned SLEW    = 5,
  parameter int unsigned SW      = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       bnd_i,
  input  logic signed [DRIFT_W-1:0]  drift_i,
  input  logic                       strobe_i,
  output logic signed [SW-1:0]       take_o,
  output logic signed [PEND_W-1:0]   pend_o
);
  localparam longint PMAX = (longint'(1) <<< (PEND_W - 1)) - 1;

  logic signed [PEND_W-1:0] pend_q, pend_d;
  longint take_l, acc;

  always_comb begin
    take_l = dtg_pkg::sclamp(longint'(pend_q), longint'(SLEW));
    take_o = en_i ? SW'(take_l) : '0;
    acc    = longint'(pend_q);
    if (strobe_i) acc = acc - take_l;
    if (bnd_i)    acc = acc + longint'(drift_i);
    acc    = dtg_pkg::sclamp(acc, PMAX);
    pend_d = en_i ? PEND_W'(acc) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dtg_delta_ctr.sv
module dtg_delta_ctr #(
  parameter int unsigned NOM  = 25,
  parameter int unsigned SLEW = 5,
  parameter int unsigned SW   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic signed [SW-1:0]  take_i,
  output logic                  strobe_o
);
  localparam int unsigned LEN_W = $clog2(NOM + SLEW + 1);

  logic [LEN_W-1:0] cnt_q, len_q, len_d;

  always_comb begin
    strobe_o = (cnt_q == len_q - LEN_W'(1));
    len_d    = en_i ? LEN_W'(int'(NOM) - int'(take_i)) : LEN_W'(NOM);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= LEN_W'(NOM);
    end else if (strobe_o) begin
      cnt_q <= '0;
      len_q <= len_d;
    end else begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/dtg_delta_gen.sv
module dtg_delta_gen #(
  parameter int unsigned NOM_TICKS  = dtg_pkg::NOM_TICKS,
  parameter int unsigned SLEW_TICKS = dtg_pkg::SLEW_TICKS,
  parameter int unsigned FRAC_W     = dtg_pkg::FRAC_W,
  parameter int unsigned PER_W      = dtg_pkg::PER_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [FRAC_W+1:0]  ptp_inc_i,
  input  logic [PER_W-1:0]   period_i,
  output logic               strobe_o
);
  localparam int unsigned DRIFT_W = PER_W + 3;
  localparam int unsigned PEND_W  = DRIFT_W + 2;
  localparam int unsigned SW      = $clog2(SLEW_TICKS + 1) + 1;

  logic                      bnd;
  logic signed [DRIFT_W-1:0] drift;
  logic signed [SW-1:0]      take;
  logic signed [PEND_W-1:0]  pend;

  dtg_period_meter #(.PER_W(PER_W), .FRAC_W(FRAC_W)) u_meter (
    .clk_i, .rst_ni, .en_i, .ptp_inc_i, .period_i,
    .bnd_o(bnd), .drift_o(drift)
  );

  dtg_corr_bank #(.DRIFT_W(DRIFT_W), .PEND_W(PEND_W), .SLEW(SLEW_TICKS), .SW(SW)) u_bank (
    .clk_i, .rst_ni, .en_i, .bnd_i(bnd), .drift_i(drift),
    .strobe_i(strobe_o), .take_o(take), .pend_o(pend)
  );

  dtg_delta_ctr #(.NOM(NOM_TICKS), .SLEW(SLEW_TICKS), .SW(SW)) u_ctr (
    .clk_i, .rst_ni, .en_i, .take_i(take), .strobe_o
  );
endmodule

// File: rtl/dtg_delta_gen_chk.sv
module dtg_delta_gen_chk #(
  parameter int unsigned NOM    = 25,
  parameter int unsigned SLEW   = 5,
  parameter int unsigned PER_W  = 20,
  parameter int unsigned PEND_W = 25
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      en_i,
  input logic [PER_W-1:0]          period_i,
  input logic                      strobe_o,
  input logic signed [PEND_W-1:0]  pend
);
  logic [7:0] len_c;
  logic       seen, nomd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_c <= '0;
      seen  <= 1'b0;
      nomd  <= 1'b1;
    end else if (strobe_o) begin
      len_c <= '0;
      seen  <= 1'b1;
      nomd  <= !en_i;
    end else if (len_c != 8'hff) begin
      len_c <= len_c + 8'd1;
    end
  end

  p_single_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);

  p_len_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && seen) |-> (int'(len_c) + 1 >= int'(NOM - SLEW)) && (int'(len_c) + 1 <= int'(NOM + SLEW)));

  p_disabled_nominal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && seen && nomd) |-> (int'(len_c) + 1 == int'(NOM)));

  p_pend_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pend == '0));

  p_hold_no_period_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && period_i == '0 && !strobe_o) |=> $stable(pend));
endmodule

bind dtg_delta_gen dtg_delta_gen_chk #(
  .NOM(NOM_TICKS), .SLEW(SLEW_TICKS), .PER_W(PER_W), .PEND_W(PEND_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .period_i(period_i),
  .strobe_o(strobe_o), .pend(pend)
);

// File: tb/dtg_delta_gen_tb.sv
`timescale 1ns/1ps
module dtg_delta_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [17:0] ptp_inc_i = 18'h10000;
  logic [19:0] period_i = '0;
  logic        strobe_o;

  int checks = 0, fails = 0;
  int cyc = 0;
  int ts [64];
  int n = 0;
  int dbl = 0;
  logic prev_s = 1'b0;
  bit done = 0;

  dtg_delta_gen dut_i (.*);

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (strobe_o) begin
      if (prev_s) dbl++;
      if (n < 64) begin ts[n] = cyc; n++; end
    end
    prev_s = strobe_o;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int k);
    repeat (k) @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset;
    step(5);
    chk(n == 0, "R1 strobe in reset", n, 0);
    rst_ni = 1'b1;
    n = 0;
    begin
      int b = cyc;
      step(80);
      chk(n >= 3, "R1 strobe count", n, 3);
      chk(ts[0] == b + 24, "R1 first strobe", ts[0] - b, 24);
      for (int i = 1; i < 3; i++) chk(ts[i] - ts[i-1] == 25, "R1 nominal", ts[i] - ts[i-1], 25);
    end
  endtask

  task automatic all_nominal(string req, int k);
    n = 0;
    step(k);
    chk(n >= 4, {req, " strobes"}, n, 4);
    for (int i = 1; i < n; i++) chk(ts[i] - ts[i-1] == 25, req, ts[i] - ts[i-1], 25);
  endtask

  task automatic t_disabled;
    en_i = 1'b0; ptp_inc_i = 18'h20000; period_i = 20'd10;
    all_nominal("R3", 300);
  endtask

  task automatic t_nominal_rate;
    en_i = 1'b1; ptp_inc_i = 18'h10000; period_i = 20'd100;
    all_nominal("R4", 500);
    en_i = 1'b0; step(30);
  endtask

  task automatic t_no_period;
    en_i = 1'b1; ptp_inc_i = 18'h18000; period_i = 20'd0;
    all_nominal("R11", 400);
    en_i = 1'b0; step(30);
  endtask

  // drift pattern: n1 deltas of l1, then n2 of l2, then nominal
  task automatic t_corr(string req, logic [17:0] inc, int bk, int l1, int n1, int l2, int n2);
    int e0, j;
    n = 0;
    en_i = 1'b1; ptp_inc_i = inc; period_i = 20'd100;
    e0 = cyc;
    step(bk + 20);
    period_i = 20'd0;
    step(400);
    j = -1;
    for (int i = 0; i < n; i++) if (j < 0 && ts[i] >= e0 + bk) j = i;
    chk(j >= 1 && j + 9 < n, {req, " strobes around boundary"}, j, 1);
    if (j >= 1 && j + 9 < n) begin
      for (int i = 1; i <= j; i++)
        chk(ts[i] - ts[i-1] == 25, "R9 delta before boundary", ts[i] - ts[i-1], 25);
      for (int m = 0; m < 8; m++) begin
        int exp = (m < n1) ? l1 : (m < n1 + n2) ? l2 : 25;
        chk(ts[j+m+1] - ts[j+m] == exp, req, ts[j+m+1] - ts[j+m], exp);
      end
    end
    en_i = 1'b0;
    step(30);
  endtask

  task automatic t_disable_clears;
    int e0, d, j;
    n = 0;
    en_i = 1'b1; ptp_inc_i = 18'h14000; period_i = 20'd100;
    e0 = cyc;
    step(82);
    en_i = 1'b0;
    d = cyc;
    step(100);
    en_i = 1'b1; ptp_inc_i = 18'h10000; period_i = 20'd0;
    step(300);
    j = -1;
    for (int i = 0; i < n; i++) if (j < 0 && ts[i] >= d) j = i;
    chk(j >= 0 && j + 10 < n, "R10 strobes", j, 0);
    if (j >= 0) for (int i = j + 1; i < n; i++)
      chk(ts[i] - ts[i-1] == 25, "R10 no residual correction", ts[i] - ts[i-1], 25);
    en_i = 1'b0;
    step(30);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_nominal_rate();
    t_no_period();
    t_corr("R5 fast shortens", 18'h14000, 80, 20, 4, 25, 0);
    t_corr("R6 slow lengthens", 18'h0CCCD, 125, 30, 5, 25, 0);
    t_corr("R8 carry", 18'h1147B, 93, 20, 1, 23, 1);
    t_disable_clears();
    chk(dbl == 0, "R2 single-cycle strobe", dbl, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule